// File: doc/BRIEF.md
# Single-Inductor Buck/Boost Switch Sequencer

This block is the digital heart of a single-inductor converter that feeds one step-down (buck) rail and one step-up (boost) rail. Every switching period it walks the inductor through a fixed list of current paths by closing groups of power switches. It reacts to comparator flags that tell it when each path has done its job. The comparators, the load-dependent peak-current level, the error amplifiers and the gate drivers all sit outside the block, so each appears only as a one-bit flag.

There are two sequences. In the normal PWM sequence the period opens with a path that feeds the buck rail while the inductor charges slowly. The hysteresis sequence is chosen when a power comparator reports that the buck load draws more than the boost load. It opens instead with a direct-feed path that sends the residual inductor current to the buck rail without adding energy. After the opening path, both sequences charge to peak, discharge into the boost rail, and freewheel until the next period. Between any two paths every switch is held open for a programmable dead-time.

A period that runs long is cut off. The sequencer drops to freewheel for one cycle, starts the new period, and records the event in a sticky flag.

States: `ST_IDLE` (after reset), `ST_P0` (direct buck feed), `ST_P1` (buck feed with slow charge), `ST_P3` (full-slope charge), `ST_P4` (boost discharge), `ST_P6` (freewheel), `ST_GAP` (dead-time, all open, remembers its target).

Transitions: idle-to-start, opening-path-done, peak-reached, delivery-done, period-restart, overrun-cut, and gap-expired.

Top module: `simo_seq`

## Requirements
- R1: A synchronous reset drives every switch enable low, clears `overrun` and `hyst_active`, and puts the sequencer in idle. In idle all enables stay low until a `period_start` pulse arrives, and a reset in the middle of a period also clears everything at the next edge.
- R2: `sw_en` bit k drives switch k+1, so bit0=SW1 and so on up to bit5=SW6. The legal patterns are 6'b001001 (SW1+SW4), 6'b101000 (SW4+SW6), 6'b000100 (SW3), 6'b010000 (SW5) and 6'b100000 (SW6). SW2 is never closed, and no more than two enables are high at once.
- R3: In PWM mode (`hyst_active`=0) a period runs SW1+SW4, then SW3, then SW5, then SW6. SW1+SW4 ends on `buck_done`, SW3 ends on `at_peak`, and SW5 ends on `boost_done`.
- R4: In hysteresis mode (`hyst_active`=1) a period runs SW4+SW6, then SW3, then SW5, then SW6. SW4+SW6 ends on `buck_above_win`.
- R5: `hyst_req` is sampled only at the clock edge that accepts a `period_start`, and the sampled value appears on `hyst_active`. A change of `hyst_req` during a period does not change that period's sequence.
- R6: Between any two successive switch patterns all enables are low for exactly D clocks, where D is `dead_cycles`. A value of 0 is treated as 1.
- R7: The freewheel pattern SW6 is held until the next `period_start`. After that pulse come a dead-time gap and then the opening path of the new period.
- R8: If `period_start` arrives before the period's `boost_done` has been taken, the sequencer goes, after a dead-time, to SW6 for exactly one clock. It then takes a dead-time and starts the new period in the mode sampled with that pulse. `overrun` rises and stays high until reset.
- R9: From idle, the opening path's enables are high in the cycle right after the edge that accepts `period_start`, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| period_start | input | 1 | One-clock pulse marking the start of a switching period |
| hyst_req | input | 1 | Power comparator: 1 selects the hysteresis sequence |
| buck_done | input | 1 | Buck regulation reached (ends SW1+SW4 path) |
| buck_above_win | input | 1 | Buck voltage crossed its upper window edge (ends SW4+SW6 path) |
| at_peak | input | 1 | Inductor current reached the peak level (ends SW3 path) |
| boost_done | input | 1 | Boost charge delivered (ends SW5 path) |
| dead_cycles | input | DT_W | Dead-time length in clocks (0 acts as 1) |
| sw_en | output | 6 | Power-switch enables, bit k = SW(k+1) |
| hyst_active | output | 1 | Mode latched for the current period |
| overrun | output | 1 | Sticky: a period was cut short |

## Verification
A wrong state or a wrong target register shows up at the ports as an illegal or out-of-order enable pattern. This appears at the first dead-time expiry after the fault, at most D+1 clocks later. A miscounted dead-time timer shows as a gap of the wrong length in the same cycle that the next pattern closes. A mode latch that follows `hyst_req` outside the period edge flips `hyst_active` one clock after the input moves. A lost overrun decision shows as a missing one-clock SW6 pulse before the new opening path.

// File: rtl/simo_pkg.sv
package simo_pkg;

    localparam int NSW = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_P0,
        ST_P1,
        ST_P3,
        ST_P4,
        ST_P6,
        ST_GAP
    } path_e;

    // Switch index k is SW(k+1)
    localparam int SW1 = 0;
    localparam int SW3 = 2;
    localparam int SW4 = 3;
    localparam int SW5 = 4;
    localparam int SW6 = 5;

    function automatic logic [NSW-1:0] path_mask(input path_e p);
        logic [NSW-1:0] m;
        m = '0;
        case (p)
            ST_P0: begin m[SW4] = 1'b1; m[SW6] = 1'b1; end
            ST_P1: begin m[SW1] = 1'b1; m[SW4] = 1'b1; end
            ST_P3: m[SW3] = 1'b1;
            ST_P4: m[SW5] = 1'b1;
            ST_P6: m[SW6] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic path_e opening_path(input logic hyst);
        return hyst ? ST_P0 : ST_P1;
    endfunction

endpackage

// File: rtl/simo_gap_timer.sv
module simo_gap_timer #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            expired
);
    localparam logic [DT_W-1:0] ONE = {{(DT_W-1){1'b0}}, 1'b1};

    logic [DT_W-1:0] cnt_q;
    logic [DT_W-1:0] limit;

    assign limit   = (dead_cycles == '0) ? ONE : dead_cycles;
    assign expired = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= ONE;
        end else if (!expired) begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/simo_sw_decode.sv
module simo_sw_decode
    import simo_pkg::*;
(
    input  path_e          state,
    output logic [NSW-1:0] sw_en
);
    always_comb begin
        sw_en = path_mask(state);
    end
endmodule

// File: rtl/simo_seq.sv
module simo_seq
    import simo_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            period_start,
    input  logic            hyst_req,
    input  logic            buck_done,
    input  logic            buck_above_win,
    input  logic            at_peak,
    input  logic            boost_done,
    input  logic [DT_W-1:0] dead_cycles,
    output logic [NSW-1:0]  sw_en,
    output logic            hyst_active,
    output logic            overrun
);
    path_e state_q, state_d;
    path_e tgt_q, tgt_d;
    logic  mode_q, mode_d;
    logic  pend_q, pend_d;
    logic  dlv_q, dlv_d;
    logic  ovr_q, ovr_d;
    logic  accept, cut, gap_go, gap_done;

    simo_gap_timer #(.DT_W(DT_W)) u_gap (
        .clk         (clk),
        .rst         (rst),
        .load        (gap_go),
        .dead_cycles (dead_cycles),
        .expired     (gap_done)
    );

    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        mode_d  = mode_q;
        pend_d  = pend_q;
        dlv_d   = dlv_q;
        ovr_d   = ovr_q;
        gap_go  = 1'b0;

        accept = period_start && !pend_q;
        cut    = accept && !dlv_q &&
                 (state_q == ST_P0 || state_q == ST_P1 || state_q == ST_P3 ||
                  state_q == ST_P4 || state_q == ST_GAP);

        if (accept) mode_d = hyst_req;
        if (cut) begin
            ovr_d  = 1'b1;
            pend_d = 1'b1;
            tgt_d  = ST_P6;
        end

        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = opening_path(hyst_req);
                    dlv_d   = 1'b0;
                end
            end
            ST_P0: begin
                if (cut) gap_go = 1'b1;
                else if (buck_above_win) begin
                    tgt_d  = ST_P3;
                    gap_go = 1'b1;
                end
            end
            ST_P1: begin
                if (cut) gap_go = 1'b1;
                else if (buck_done) begin
                    tgt_d  = ST_P3;
                    gap_go = 1'b1;
                end
            end
            ST_P3: begin
                if (cut) gap_go = 1'b1;
                else if (at_peak) begin
                    tgt_d  = ST_P4;
                    gap_go = 1'b1;
                end
            end
            ST_P4: begin
                if (cut) gap_go = 1'b1;
                else if (boost_done) begin
                    tgt_d  = ST_P6;
                    dlv_d  = 1'b1;
                    gap_go = 1'b1;
                end
            end
            ST_P6: begin
                if (pend_q || accept) begin
                    tgt_d  = opening_path(mode_d);
                    pend_d = 1'b1;
                    gap_go = 1'b1;
                end
            end
            ST_GAP: begin
                if (accept && dlv_q) pend_d = 1'b1;
                if (gap_done) begin
                    state_d = tgt_d;
                    if (tgt_d == ST_P0 || tgt_d == ST_P1) begin
                        pend_d = 1'b0;
                        dlv_d  = 1'b0;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (gap_go) state_d = ST_GAP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= ST_IDLE;
            mode_q  <= 1'b0;
            pend_q  <= 1'b0;
            dlv_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            mode_q  <= mode_d;
            pend_q  <= pend_d;
            dlv_q   <= dlv_d;
            ovr_q   <= ovr_d;
        end
    end

    simo_sw_decode u_dec (
        .state (state_q),
        .sw_en (sw_en)
    );

    assign hyst_active = mode_q;
    assign overrun     = ovr_q;
endmodule

// File: rtl/simo_seq_chk.sv
module simo_seq_chk
    import simo_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           period_start,
    input logic [NSW-1:0] sw_en,
    input logic           hyst_active,
    input logic           overrun
);
    logic           rst_q;
    logic           live_q;
    logic [NSW-1:0] last_nz_q;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        live_q <= !rst;
        if (rst) last_nz_q <= '0;
        else if (sw_en != '0) last_nz_q <= sw_en;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (sw_en == '0 && !overrun && !hyst_active));

    // R2
    two_switch_max_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(sw_en) <= 2 && !sw_en[1]));

    // R6
    gap_between_paths_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sw_en) != '0 && sw_en != '0) |-> sw_en == $past(sw_en));

    // R3
    boost_after_charge_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && $rose(sw_en[SW5])) |-> last_nz_q == 6'b000100);

    // R4
    charge_after_open_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && $rose(sw_en[SW3])) |-> (last_nz_q == 6'b001001 || last_nz_q == 6'b101000));

    // R5
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !period_start |=> $stable(hyst_active));

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

bind simo_seq simo_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .period_start (period_start),
    .sw_en        (sw_en),
    .hyst_active  (hyst_active),
    .overrun      (overrun)
);

// File: tb/tb_simo_seq.sv
module tb_simo_seq;
    localparam logic [5:0] PAT_P0 = 6'b101000;
    localparam logic [5:0] PAT_P1 = 6'b001001;
    localparam logic [5:0] PAT_P3 = 6'b000100;
    localparam logic [5:0] PAT_P4 = 6'b010000;
    localparam logic [5:0] PAT_P6 = 6'b100000;

    // {mode, dead, t_open, t_peak, t_boost}
    localparam int NV = 6;
    localparam logic [19:0] VEC [0:NV-1] = '{
        {1'b0, 4'd2,  5'd3, 5'd4, 5'd2},
        {1'b1, 4'd1,  5'd2, 5'd5, 5'd3},
        {1'b0, 4'd0,  5'd1, 5'd1, 5'd1},
        {1'b1, 4'd15, 5'd4, 5'd2, 5'd6},
        {1'b1, 4'd3,  5'd1, 5'd1, 5'd1},
        {1'b0, 4'd7,  5'd5, 5'd6, 5'd2}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       period_start = 1'b0;
    logic       hyst_req = 1'b0;
    logic       buck_done = 1'b0;
    logic       buck_above_win = 1'b0;
    logic       at_peak = 1'b0;
    logic       boost_done = 1'b0;
    logic [3:0] dead_cycles = 4'd2;
    logic [5:0] sw_en;
    logic       hyst_active;
    logic       overrun;

    simo_seq dut (
        .clk(clk), .rst(rst), .period_start(period_start), .hyst_req(hyst_req),
        .buck_done(buck_done), .buck_above_win(buck_above_win), .at_peak(at_peak),
        .boost_done(boost_done), .dead_cycles(dead_cycles), .sw_en(sw_en),
        .hyst_active(hyst_active), .overrun(overrun)
    );

    int total = 0, bad = 0;
    int t_open = 3, t_peak = 3, t_boost = 2, dt_exp = 2;
    int run = 0, zeros = 0, rec_cnt = 0, gap_bad = 0, pat_bad = 0;
    bit seen_nz = 0, finished = 0;
    logic [5:0] last_sw = '0;
    logic [5:0] rec [0:63];

    // Comparator models and path monitor
    always @(negedge clk) begin
        if (rst) begin
            run = 0; zeros = 0; seen_nz = 0;
        end else begin
            if (sw_en != 0 && sw_en == last_sw) run++;
            else if (sw_en != 0) run = 1;
            else run = 0;
            if (sw_en == 0) zeros++;
            else if (last_sw == 0) begin
                if (seen_nz && zeros != dt_exp) gap_bad++;
                if (!(sw_en inside {PAT_P0, PAT_P1, PAT_P3, PAT_P4, PAT_P6})) pat_bad++;
                rec[rec_cnt % 64] = sw_en;
                rec_cnt++;
                seen_nz = 1;
                zeros = 0;
            end
        end
        buck_done      = !rst && sw_en == PAT_P1 && run >= t_open;
        buck_above_win = !rst && sw_en == PAT_P0 && run >= t_open;
        at_peak        = !rst && sw_en == PAT_P3 && run >= t_peak;
        boost_done     = !rst && sw_en == PAT_P4 && run >= t_boost;
        last_sw = sw_en;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_sw(input logic [5:0] pat, input string req);
        int n = 0;
        while (sw_en != pat && n < 4000) begin
            tick();
            n++;
        end
        chk(sw_en == pat, req, "pattern reached", int'(sw_en), int'(pat));
    endtask

    task automatic check_seq(input int base, input bit mode, input string req);
        logic [5:0] e [0:3];
        int errs = 0;
        e[0] = mode ? PAT_P0 : PAT_P1;
        e[1] = PAT_P3;
        e[2] = PAT_P4;
        e[3] = PAT_P6;
        for (int i = 0; i < 4; i++)
            if (rec[(base + i) % 64] != e[i]) errs++;
        chk(errs == 0 && rec_cnt - base == 4, req, "path order (paths, mismatches*100)",
            (rec_cnt - base) + 100 * errs, 4);
    endtask

    task automatic pulse();
        period_start = 1'b1;
        tick();
        period_start = 1'b0;
    endtask

    task automatic run_period(input bit mode, input int dt, input int tb,
                              input int tp, input int tq);
        int base, gb, pb;
        hyst_req = mode;
        dead_cycles = 4'(dt);
        dt_exp = (dt == 0) ? 1 : dt;
        t_open = tb; t_peak = tp; t_boost = tq;
        gb = gap_bad; pb = pat_bad; base = rec_cnt;
        pulse();
        wait_sw(PAT_P6, "R7");
        check_seq(base, mode, mode ? "R4" : "R3");
        chk(gap_bad == gb, "R6", "dead-time gap errors", gap_bad - gb, 0);
        chk(pat_bad == pb && hyst_active == mode, "R5/R2", "mode latched, legal patterns",
            int'(hyst_active), int'(mode));
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", "run finished", 0, 1);
        report();
    end

    initial begin
        int base;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(sw_en == 0 && !overrun && !hyst_active, "R1", "reset state", int'(sw_en), 0);
        repeat (8) tick();
        chk(sw_en == 0, "R1", "idle holds without period start", int'(sw_en), 0);

        // R9 first path without gap from idle
        hyst_req = 0; dead_cycles = 4'd2; dt_exp = 2;
        t_open = 3; t_peak = 3; t_boost = 2;
        base = rec_cnt;
        pulse();
        chk(sw_en == PAT_P1, "R9", "opening path right after start", int'(sw_en), int'(PAT_P1));
        wait_sw(PAT_P6, "R7");
        check_seq(base, 0, "R3");
        repeat (5) tick();
        chk(sw_en == PAT_P6, "R7", "freewheel held", int'(sw_en), int'(PAT_P6));

        // Table walk: R3 R4 R5 R6
        for (int i = 0; i < NV; i++)
            run_period(VEC[i][19], int'(VEC[i][18:15]), int'(VEC[i][14:10]),
                       int'(VEC[i][9:5]), int'(VEC[i][4:0]));

        // R5 mode input moved mid-period is ignored
        hyst_req = 0; dead_cycles = 4'd2; dt_exp = 2;
        t_open = 2; t_peak = 6; t_boost = 2;
        base = rec_cnt;
        pulse();
        wait_sw(PAT_P3, "R5");
        hyst_req = 1;
        tick();
        chk(hyst_active == 0, "R5", "mode unchanged mid-period", int'(hyst_active), 0);
        wait_sw(PAT_P6, "R5");
        check_seq(base, 0, "R5");

        // R8 overrun
        hyst_req = 0; t_peak = 1000;
        chk(overrun == 0, "R8", "no overrun before cut", int'(overrun), 0);
        pulse();
        wait_sw(PAT_P3, "R8");
        repeat (4) tick();
        base = rec_cnt;
        pulse();
        while (rec_cnt - base < 2) tick();
        t_peak = 3;
        chk(rec[base % 64] == PAT_P6 && rec[(base + 1) % 64] == PAT_P1, "R8",
            "freewheel then new opening path", int'(rec[base % 64]), int'(PAT_P6));
        chk(overrun == 1, "R8", "overrun raised", int'(overrun), 1);
        wait_sw(PAT_P6, "R8");
        chk(rec_cnt - base == 5, "R8", "single-cycle freewheel then full period",
            rec_cnt - base, 5);
        run_period(1, 3, 2, 2, 2);
        chk(overrun == 1, "R8", "overrun sticky", int'(overrun), 1);

        // R1 reset mid-period
        hyst_req = 0; t_peak = 1000;
        pulse();
        wait_sw(PAT_P3, "R1");
        rst = 1'b1;
        tick();
        chk(sw_en == 0 && !overrun, "R1", "reset mid-period clears", int'(sw_en) + int'(overrun), 0);
        rst = 1'b0;
        t_peak = 3;
        repeat (5) tick();
        chk(sw_en == 0 && !hyst_active, "R1", "idle after reset", int'(sw_en), 0);

        report();
    end
endmodule